// File: doc/BRIEF.md
# Host-to-Controller Mailbox with Indirect SRAM Window

This block sits between a host processor and an embedded controller that share a 256-byte SRAM. The host sees a small byte-wide register file. It reaches the SRAM through an offset register and a data register. It hands work to the controller through a message byte, a command byte and a status byte. The host puts a program start offset in the message byte and raises the request bit in the command byte. The controller answers by accepting, and later by finishing or failing.

While the controller owns the SRAM, the controller's memory port drives the single RAM port and the host's window is fenced off. The host's window takes the port back when ownership returns. A parameter picks which of two register layouts the window uses. A version query through an index/data pair tells software which layout is present.

Top module: `mbox_sram_window`

## Requirements
- R1: After the synchronous active-high reset, every host-readable register (command at 0x14, message at 0x15, index at 0x16, status at 0x18, window offset) reads 0x00 and `ctl_start` is low.
- R2: Writing an offset to the window offset register makes the next data-register write or read reach the SRAM byte at that offset. The offset does not advance, so repeated reads return the same byte.
- R3: With `LAYOUT_V2`=1 the offset register is at 0x12 and the data register at 0x13. With `LAYOUT_V2`=0 they are at 0x0A and 0x0D, and the other pair of addresses has no effect.
- R4: After 0x1F is written to the index register (0x16), reading 0x17 returns 0x01 for the newer layout and 0x00 for the older one. Any other index value makes 0x17 read 0x00.
- R5: A host write to the command register that sets bit 0 produces a one-cycle `ctl_start` pulse carrying the message register value. It does so only when bit 0 was clear, the status acknowledge bit is clear and no request is pending. Otherwise no pulse is produced.
- R6: `ctl_accept` for a pending request sets status bit 0 (acknowledge). `ctl_done` clears it.
- R7: `ctl_err` sets status bit 1 (error) and clears acknowledge. Error stays set until the host writes 0x00 to the command register while acknowledge is clear.
- R8: While command bit 0 or acknowledge is set, host data-register writes leave the SRAM unchanged and data-register reads return 0xFF.
- R9: Controller memory writes take effect only while the controller owns the SRAM. Bytes it writes then are visible to the host after release.
- R10: Host reads of the command, message and offset registers return the last values written. Read data appears one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_we | input | 1 | Host register write strobe |
| hst_re | input | 1 | Host register read strobe |
| hst_addr | input | 8 | Host register offset |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data, valid the cycle after `hst_re` |
| ctl_start | output | 1 | One-cycle program start pulse |
| ctl_start_addr | output | 8 | Program start offset carried with the pulse |
| ctl_accept | input | 1 | Controller accepts the pending request |
| ctl_done | input | 1 | Controller finished the program |
| ctl_err | input | 1 | Controller refused or failed the request |
| ctl_mem_we | input | 1 | Controller SRAM write enable |
| ctl_mem_addr | input | 8 | Controller SRAM offset |
| ctl_mem_wdata | input | 8 | Controller SRAM write data |
| ctl_mem_rdata | output | 8 | SRAM read data, one cycle after the offset |

## Verification
The window is exercised with distinct bytes at neighbouring offsets, and each offset is read back twice. This separates a correct fixed offset from an auto-incrementing one or from aliasing. Two instances with different layout settings receive the same host traffic at both address pairs, which shows that each decodes only its own window. The handshake runs through its ordered patterns: a normal accept/release/done sequence, an error refusal followed by a clear, and repeated requests while the controller is busy. In each case the window is probed during ownership and controller writes are made both inside and outside ownership. This separates the ownership fence from plain arbitration.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam logic [7:0] OFS_CMD    = 8'h14;
  localparam logic [7:0] OFS_MSG    = 8'h15;
  localparam logic [7:0] OFS_IDX    = 8'h16;
  localparam logic [7:0] OFS_IDXDAT = 8'h17;
  localparam logic [7:0] OFS_STAT   = 8'h18;
  localparam logic [7:0] VER_KEY    = 8'h1F;
  localparam logic [7:0] WIN_A_NEW  = 8'h12;
  localparam logic [7:0] WIN_D_NEW  = 8'h13;
  localparam logic [7:0] WIN_A_OLD  = 8'h0A;
  localparam logic [7:0] WIN_D_OLD  = 8'h0D;
endpackage

// File: rtl/mbox_sram.sv
module mbox_sram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/mbox_handshake.sv
module mbox_handshake #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_wr,
  input  logic          msg_wr,
  input  logic [DW-1:0] wdata,
  input  logic          ctl_accept,
  input  logic          ctl_done,
  input  logic          ctl_err,
  output logic [DW-1:0] cmd_q,
  output logic [DW-1:0] msg_q,
  output logic          ack_q,
  output logic          err_q,
  output logic          own,
  output logic          ctl_start,
  output logic [DW-1:0] ctl_start_addr
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q          <= '0;
      msg_q          <= '0;
      ack_q          <= 1'b0;
      err_q          <= 1'b0;
      pend_q         <= 1'b0;
      ctl_start      <= 1'b0;
      ctl_start_addr <= '0;
    end else begin
      ctl_start <= 1'b0;
      if (msg_wr) msg_q <= wdata;
      if (cmd_wr) begin
        cmd_q <= wdata;
        if (wdata[0] && !cmd_q[0] && !ack_q && !pend_q) begin
          ctl_start      <= 1'b1;
          ctl_start_addr <= msg_q;
          pend_q         <= 1'b1;
        end
        if (wdata == '0 && !ack_q) err_q <= 1'b0;
      end
      if (ctl_err) begin
        err_q  <= 1'b1;
        ack_q  <= 1'b0;
        pend_q <= 1'b0;
      end else if (ctl_accept && pend_q) begin
        ack_q  <= 1'b1;
        pend_q <= 1'b0;
      end else if (ctl_done && ack_q) begin
        ack_q <= 1'b0;
      end
    end
  end

  assign own = cmd_q[0] | ack_q;

  // R5
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_start |=> !ctl_start);
  // R5
  start_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_start |-> $past(cmd_wr && !ack_q));
  // R6
  ack_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_q) |-> $past(ctl_accept));
  // R7
  err_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> $past(ctl_err));
endmodule

// File: rtl/mbox_host_if.sv
module mbox_host_if
  import mbox_pkg::*;
#(
  parameter int DW        = 8,
  parameter int AW        = 8,
  parameter bit LAYOUT_V2 = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hst_we,
  input  logic          hst_re,
  input  logic [7:0]    hst_addr,
  input  logic [DW-1:0] hst_wdata,
  input  logic [DW-1:0] cmd_q,
  input  logic [DW-1:0] msg_q,
  input  logic          ack_q,
  input  logic          err_q,
  input  logic          own,
  input  logic [DW-1:0] ram_q,
  output logic          cmd_wr,
  output logic          msg_wr,
  output logic          win_we,
  output logic [AW-1:0] win_addr,
  output logic [DW-1:0] hst_rdata
);
  localparam logic [7:0] WIN_A = LAYOUT_V2 ? WIN_A_NEW : WIN_A_OLD;
  localparam logic [7:0] WIN_D = LAYOUT_V2 ? WIN_D_NEW : WIN_D_OLD;
  localparam logic [DW-1:0] VER_VAL = LAYOUT_V2 ? DW'(1) : DW'(0);

  logic [DW-1:0] idx_q, rd_q, reg_v;
  logic          rd_mem_q, rd_own_q;

  assign cmd_wr = hst_we && hst_addr == OFS_CMD;
  assign msg_wr = hst_we && hst_addr == OFS_MSG;
  assign win_we = hst_we && hst_addr == WIN_D && !own;

  always_comb begin
    reg_v = '0;
    if (hst_addr == WIN_A)      reg_v = DW'(win_addr);
    else if (hst_addr == OFS_CMD)    reg_v = cmd_q;
    else if (hst_addr == OFS_MSG)    reg_v = msg_q;
    else if (hst_addr == OFS_IDX)    reg_v = idx_q;
    else if (hst_addr == OFS_IDXDAT) reg_v = (idx_q == DW'(VER_KEY)) ? VER_VAL : '0;
    else if (hst_addr == OFS_STAT)   reg_v = DW'({err_q, ack_q});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      win_addr <= '0;
      rd_q     <= '0;
      rd_mem_q <= 1'b0;
      rd_own_q <= 1'b0;
    end else begin
      if (hst_we && hst_addr == WIN_A)   win_addr <= hst_wdata[AW-1:0];
      if (hst_we && hst_addr == OFS_IDX) idx_q <= hst_wdata;
      if (hst_re) begin
        rd_q     <= reg_v;
        rd_mem_q <= (hst_addr == WIN_D);
        rd_own_q <= own;
      end
    end
  end

  assign hst_rdata = rd_mem_q ? (rd_own_q ? '1 : ram_q) : rd_q;
endmodule

// File: rtl/mbox_sram_window.sv
module mbox_sram_window #(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter bit LAYOUT_V2 = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hst_we,
  input  logic          hst_re,
  input  logic [7:0]    hst_addr,
  input  logic [DW-1:0] hst_wdata,
  output logic [DW-1:0] hst_rdata,
  output logic          ctl_start,
  output logic [DW-1:0] ctl_start_addr,
  input  logic          ctl_accept,
  input  logic          ctl_done,
  input  logic          ctl_err,
  input  logic          ctl_mem_we,
  input  logic [AW-1:0] ctl_mem_addr,
  input  logic [DW-1:0] ctl_mem_wdata,
  output logic [DW-1:0] ctl_mem_rdata
);
  logic [DW-1:0] cmd_q, msg_q, ram_q, ram_wd;
  logic          ack_q, err_q, own, cmd_wr, msg_wr, win_we, ram_we;
  logic [AW-1:0] win_addr, ram_addr;

  mbox_handshake #(.DW(DW)) u_hs (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .msg_wr(msg_wr), .wdata(hst_wdata),
    .ctl_accept(ctl_accept), .ctl_done(ctl_done), .ctl_err(ctl_err),
    .cmd_q(cmd_q), .msg_q(msg_q), .ack_q(ack_q), .err_q(err_q), .own(own),
    .ctl_start(ctl_start), .ctl_start_addr(ctl_start_addr)
  );

  mbox_host_if #(.DW(DW), .AW(AW), .LAYOUT_V2(LAYOUT_V2)) u_host (
    .clk(clk), .rst(rst), .hst_we(hst_we), .hst_re(hst_re), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .cmd_q(cmd_q), .msg_q(msg_q), .ack_q(ack_q),
    .err_q(err_q), .own(own), .ram_q(ram_q), .cmd_wr(cmd_wr), .msg_wr(msg_wr),
    .win_we(win_we), .win_addr(win_addr), .hst_rdata(hst_rdata)
  );

  assign ram_we   = own ? ctl_mem_we    : win_we;
  assign ram_addr = own ? ctl_mem_addr  : win_addr;
  assign ram_wd   = own ? ctl_mem_wdata : hst_wdata;

  mbox_sram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wd), .rdata(ram_q)
  );

  assign ctl_mem_rdata = ram_q;
endmodule

// File: tb/tb_mbox_sram_window.sv
module tb_mbox_sram_window;
  localparam int LAT = 5;
  logic clk = 1'b0, rst = 1'b1;
  logic hst_we = 0, hst_re = 0;
  logic [7:0] hst_addr = 0, hst_wdata = 0;
  logic [7:0] rdata2, rdata1, start_addr2, start_addr1, cmrd2, cmrd1;
  logic start2, start1;
  logic ctl_accept = 0, ctl_done = 0, ctl_err = 0, ctl_mem_we = 0;
  logic [7:0] ctl_mem_addr = 0, ctl_mem_wdata = 0;
  int n_chk = 0, n_err = 0;
  logic [7:0] v2, v1;

  always #4 clk = ~clk;

  mbox_sram_window #(.LAYOUT_V2(1'b1)) dut (
    .clk(clk), .rst(rst), .hst_we(hst_we), .hst_re(hst_re), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(rdata2), .ctl_start(start2),
    .ctl_start_addr(start_addr2), .ctl_accept(ctl_accept), .ctl_done(ctl_done),
    .ctl_err(ctl_err), .ctl_mem_we(ctl_mem_we), .ctl_mem_addr(ctl_mem_addr),
    .ctl_mem_wdata(ctl_mem_wdata), .ctl_mem_rdata(cmrd2));

  mbox_sram_window #(.LAYOUT_V2(1'b0)) dut_old (
    .clk(clk), .rst(rst), .hst_we(hst_we), .hst_re(hst_re), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(rdata1), .ctl_start(start1),
    .ctl_start_addr(start_addr1), .ctl_accept(1'b0), .ctl_done(1'b0),
    .ctl_err(1'b0), .ctl_mem_we(1'b0), .ctl_mem_addr(8'h00),
    .ctl_mem_wdata(8'h00), .ctl_mem_rdata(cmrd1));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [7:0] d);
    hst_we = 1; hst_addr = a; hst_wdata = d;
    @(posedge clk); @(negedge clk);
    hst_we = 0;
  endtask

  task automatic hread(input logic [7:0] a);
    hst_re = 1; hst_addr = a;
    @(posedge clk); @(negedge clk);
    hst_re = 0; v2 = rdata2; v1 = rdata1;
  endtask

  task automatic pulse_accept(); ctl_accept = 1; @(posedge clk); @(negedge clk); ctl_accept = 0; endtask
  task automatic pulse_done();   ctl_done = 1;   @(posedge clk); @(negedge clk); ctl_done = 0;   endtask
  task automatic pulse_err();    ctl_err = 1;    @(posedge clk); @(negedge clk); ctl_err = 0;    endtask

  task automatic ctl_write(input logic [7:0] a, input logic [7:0] d);
    ctl_mem_we = 1; ctl_mem_addr = a; ctl_mem_wdata = d;
    @(posedge clk); @(negedge clk);
    ctl_mem_we = 0;
  endtask

  task automatic t_reset();
    hread(8'h14); chk("R1 cmd", v2, 8'h00);
    hread(8'h15); chk("R1 msg", v2, 8'h00);
    hread(8'h16); chk("R1 idx", v2, 8'h00);
    hread(8'h18); chk("R1 status", v2, 8'h00);
    hread(8'h12); chk("R1 offset", v2, 8'h00);
    chk("R1 start", {7'b0, start2}, 8'h00);
  endtask

  task automatic t_window();
    hwrite(8'h12, 8'h40); hwrite(8'h13, 8'hA5);
    hwrite(8'h12, 8'h41); hwrite(8'h13, 8'h3C);
    hwrite(8'h12, 8'h40);
    hread(8'h13); chk("R2 read1", v2, 8'hA5);
    hread(8'h13); chk("R2 read2 no increment", v2, 8'hA5);
    hwrite(8'h12, 8'h41);
    hread(8'h13); chk("R2 neighbour", v2, 8'h3C);
    hread(8'h12); chk("R10 offset readback", v2, 8'h41);
  endtask

  task automatic t_layout();
    hwrite(8'h0A, 8'h05); hwrite(8'h0D, 8'h77);
    hread(8'h0D); chk("R3 old layout data", v1, 8'h77);
    hread(8'h0A); chk("R3 old layout offset", v1, 8'h05);
    hread(8'h13); chk("R3 new layout unaffected", v2, 8'h3C);
    hwrite(8'h12, 8'h05);
    hread(8'h13); chk("R3 new ram untouched", v2 === 8'h77 ? 8'h01 : 8'h00, 8'h00);
    hwrite(8'h12, 8'h40);
  endtask

  task automatic t_version();
    hwrite(8'h16, 8'h1F);
    hread(8'h17); chk("R4 new version", v2, 8'h01); chk("R4 old version", v1, 8'h00);
    hwrite(8'h16, 8'h02);
    hread(8'h17); chk("R4 other index", v2, 8'h00);
  endtask

  task automatic t_run_ok();
    hwrite(8'h15, 8'h30);
    hread(8'h15); chk("R10 msg readback", v2, 8'h30);
    hwrite(8'h14, 8'h01);
    chk("R5 start pulse", {7'b0, start2}, 8'h01);
    chk("R5 start addr", start_addr2, 8'h30);
    @(posedge clk); @(negedge clk);
    chk("R5 one cycle", {7'b0, start2}, 8'h00);
    hread(8'h14); chk("R10 cmd readback", v2, 8'h01);
    hread(8'h13); chk("R8 read while requested", v2, 8'hFF);
    hwrite(8'h13, 8'h11);
    repeat (LAT) @(negedge clk);
    pulse_accept();
    hread(8'h18); chk("R6 ack set", v2, 8'h01);
    ctl_write(8'h50, 8'h9E);
    hwrite(8'h14, 8'h00);
    hread(8'h13); chk("R8 read while acked", v2, 8'hFF);
    hwrite(8'h13, 8'h22);
    repeat (LAT) @(negedge clk);
    pulse_done();
    hread(8'h18); chk("R6 ack cleared", v2, 8'h00);
    hread(8'h13); chk("R8 writes ignored", v2, 8'hA5);
    hwrite(8'h12, 8'h50);
    hread(8'h13); chk("R9 ctl write visible", v2, 8'h9E);
    hwrite(8'h12, 8'h40);
  endtask

  task automatic t_ctl_not_owner();
    ctl_write(8'h40, 8'h00);
    hread(8'h13); chk("R9 ctl write ignored when idle", v2, 8'hA5);
  endtask

  task automatic t_error();
    hwrite(8'h14, 8'h01);
    chk("R5 start for error run", {7'b0, start2}, 8'h01);
    repeat (LAT) @(negedge clk);
    pulse_err();
    hread(8'h18); chk("R7 error set", v2, 8'h02);
    hwrite(8'h14, 8'h01);
    chk("R5 no start while cmd set", {7'b0, start2}, 8'h00);
    repeat (3) @(negedge clk);
    hread(8'h18); chk("R7 error sticky", v2, 8'h02);
    hwrite(8'h14, 8'h00);
    hread(8'h18); chk("R7 error cleared", v2, 8'h00);
  endtask

  task automatic t_busy();
    hwrite(8'h14, 8'h01);
    repeat (LAT) @(negedge clk);
    pulse_accept();
    hwrite(8'h14, 8'h00);
    hwrite(8'h14, 8'h01);
    chk("R5 no start while ack", {7'b0, start2}, 8'h00);
    hwrite(8'h14, 8'h00);
    pulse_done();
    hread(8'h18); chk("R6 idle after busy", v2, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_window();
    t_layout();
    t_version();
    t_run_ok();
    t_ctl_not_owner();
    t_error();
    t_busy();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule